// File: doc/BRIEF.md
# Boot Strap Pulse-and-Sense Reader

This block works out a boot-mode code from three shared serial-flash pins (clock, MOSI and MISO) before the flash is ever addressed. The board may leave a pin open, or may fit a weak pull-up or pull-down resistor. A plain level read cannot tell an open pin from a resistor. The block therefore charges all three pins high for a short pulse, lets go of them, waits a settle window, and then samples them. A pin that has fallen back low must have a pull-down. A pin that stays high is either open (it still holds its charge) or pulled up.

A start strobe runs one measurement. While it runs, the block only ever drives the pins high, so it sends no clock edge to the flash. Chip-select is not touched. When the measurement ends, the three sampled bits are latched as the mode code and done is raised. The boot logic may use the flash pins only after done is high. The code and done stay fixed until the next start strobe is accepted. Because no strap resistor reads as a one, a board with none fitted falls into the regular boot code.

Top module: `boot_strap_probe`

## Requirements
- R1: After reset, pad_oe_o is 000, done_o is 0 and mode_o is 111.
- R2: A start_i that is high at a clock edge while the block is idle or done sets all three pad_oe_o bits to 1 from that edge on. They stay at 1 for exactly PULSE_CYC cycles and then return to 0.
- R3: Whenever a pad_oe_o bit is 1, the matching pad_out_o bit is also 1. A pin is never driven low.
- R4: done_o rises PULSE_CYC + SETTLE_CYC cycles after the edge that accepted start. All pad_oe_o bits are 0 during the settle window and while done_o is high.
- R5: A mode bit is 0 when its pin is low at sampling time (pull-down present). A pin that is pulled up or left floating reads as 1, and a floating pin reads 1 even if it was low before the pulse.
- R6: Bit mapping: mode_o[2] is the clock pin (pad index 2), mode_o[1] is MOSI (index 1) and mode_o[0] is MISO (index 0). The codes are 111 regular flash/serial boot, 110 USB boot, 101 SD card boot and 100 serial monitor.
- R7: With no strap resistor on any pin, the result is 111.
- R8: Once done_o is high, mode_o and done_o hold their values whatever the pads do, until the next start is accepted.
- R9: A start_i pulse during the drive or settle phase is ignored and does not change the done timing.
- R10: A start accepted while done is high clears done_o in the next cycle and runs a new measurement. mode_o keeps its old value until the new result is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Boot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a measurement |
| pad_in_i | input | 3 | Pad input values {clock, MOSI, MISO} |
| pad_oe_o | output | 3 | Pad output enables |
| pad_out_o | output | 3 | Pad output data |
| mode_o | output | 3 | Latched boot-mode code |
| done_o | output | 1 | Measurement complete, code valid |

## Verification
The assertions check four rules on every cycle:
- a pin is driven only high;
- the three enables move together and stay high for exactly the pulse width;
- nothing is driven while done is high;
- the code stays still while done is held, and done falls only on a start.

Only the bench scenarios can show that each pull-down, pull-up and floating combination gives the right code, and that a floating pin reads high after the pulse. The same holds for the exact done latency, for a start ignored while busy, and for a rerun that replaces the code.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_DRIVE  = 2'd1,
    SEQ_SETTLE = 2'd2,
    SEQ_HOLD   = 2'd3
  } seq_state_t;

  localparam int unsigned STRAP_PINS = 3;

  localparam logic [STRAP_PINS-1:0] MODE_REGULAR = 3'b111;
  localparam logic [STRAP_PINS-1:0] MODE_USB     = 3'b110;
  localparam logic [STRAP_PINS-1:0] MODE_SDCARD  = 3'b101;
  localparam logic [STRAP_PINS-1:0] MODE_MONITOR = 3'b100;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_pkg::*;
#(
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic drive_o,
  output logic accept_o,
  output logic capture_o
);
  localparam int unsigned LONGEST = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept_o  = start_i && (state_q == SEQ_IDLE || state_q == SEQ_HOLD);
  assign drive_o   = (state_q == SEQ_DRIVE);
  assign capture_o = (state_q == SEQ_SETTLE) && (cnt_q == SETTLE_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE, SEQ_HOLD: begin
        if (accept_o) begin
          state_d = SEQ_DRIVE;
          cnt_d   = '0;
        end
      end
      SEQ_DRIVE: begin
        if (cnt_q == PULSE_LAST) begin
          state_d = SEQ_SETTLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_SETTLE: begin
        if (capture_o) begin
          state_d = SEQ_HOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] sample_i,
  output logic [WIDTH-1:0] mode_o,
  output logic             done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '1;
      done_o <= 1'b0;
    end else begin
      if (capture_i) begin
        mode_o <= sample_i;
        done_o <= 1'b1;
      end else if (accept_i) begin
        done_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/boot_strap_probe.sv
module boot_strap_probe
  import strap_pkg::*;
#(
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [STRAP_PINS-1:0] pad_in_i,
  output logic [STRAP_PINS-1:0] pad_oe_o,
  output logic [STRAP_PINS-1:0] pad_out_o,
  output logic [STRAP_PINS-1:0] mode_o,
  output logic                  done_o
);
  logic                  drive;
  logic                  accept;
  logic                  capture;
  logic [STRAP_PINS-1:0] sampled;

  strap_seq #(
    .PULSE_CYC (PULSE_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .drive_o  (drive),
    .accept_o (accept),
    .capture_o(capture)
  );

  strap_sync #(
    .WIDTH (STRAP_PINS),
    .STAGES(SYNC_DEPTH)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pad_in_i),
    .sync_o (sampled)
  );

  strap_latch #(
    .WIDTH(STRAP_PINS)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .capture_i(capture),
    .sample_i (sampled),
    .mode_o   (mode_o),
    .done_o   (done_o)
  );

  assign pad_oe_o  = {STRAP_PINS{drive}};
  assign pad_out_o = {STRAP_PINS{drive}};
endmodule

// File: rtl/boot_strap_probe_chk.sv
module boot_strap_probe_chk #(
  parameter int unsigned PULSE_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [2:0] pad_oe_o,
  input logic [2:0] pad_out_o,
  input logic [2:0] mode_o,
  input logic       done_o
);
  localparam int unsigned RW = $clog2(PULSE_CYC + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (pad_oe_o[0]) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  p_drive_high_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & ~pad_out_o) == 3'b000);

  p_enables_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o == 3'b000) || (pad_oe_o == 3'b111));

  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_oe_o[0]) |-> (run_q == RW'(PULSE_CYC)));

  p_released_when_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pad_oe_o == 3'b000));

  p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> $stable(mode_o));

  p_done_drop_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_o) |-> $past(start_i));
endmodule

bind boot_strap_probe boot_strap_probe_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .pad_oe_o (pad_oe_o),
  .pad_out_o(pad_out_o),
  .mode_o   (mode_o),
  .done_o   (done_o)
);

// File: tb/test_boot_strap_probe.sv
module test_boot_strap_probe;
  localparam int P = 4;
  localparam int S = 16;
  localparam int PD = 0, PU = 1, FL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] pad_in_i;
  logic [2:0] pad_oe_o, pad_out_o, mode_o;
  logic       done_o;
  logic [2:0] keep_q = 3'b000;
  logic       keep_clr = 1'b0;
  int         cfg [3];
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  boot_strap_probe #(.PULSE_CYC(P), .SETTLE_CYC(S)) i_boot_strap_probe (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pad_in_i(pad_in_i),
    .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o), .mode_o(mode_o), .done_o(done_o)
  );

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      if (pad_oe_o[i])     pad_in_i[i] = pad_out_o[i];
      else if (cfg[i]==PD) pad_in_i[i] = 1'b0;
      else if (cfg[i]==PU) pad_in_i[i] = 1'b1;
      else                 pad_in_i[i] = keep_q[i];
    end
  end

  always @(posedge clk) keep_q <= keep_clr ? 3'b000 : pad_in_i;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expect_code();
    logic [2:0] c;
    for (int i = 0; i < 3; i++) c[i] = (cfg[i] == PD) ? 1'b0 : 1'b1;
    return c;
  endfunction

  task automatic run_probe(input bit poke_busy, output int oe_cnt, output int done_at,
                           output int out_bad);
    @(negedge clk); keep_clr = 1'b1;
    @(negedge clk); keep_clr = 1'b0; start_i = 1'b1;
    @(posedge clk);
    oe_cnt = 0; done_at = -1; out_bad = 0;
    for (int n = 0; n < P + S + 4; n++) begin
      @(negedge clk);
      start_i = poke_busy && (n == 2 || n == P + 3);
      if (n == 0 && done_o) out_bad++;
      if (pad_oe_o == 3'b111) oe_cnt++;
      if ((pad_oe_o & ~pad_out_o) != 3'b000) out_bad++;
      if (done_o && pad_oe_o != 3'b000) out_bad++;
      if (done_o && done_at < 0) done_at = n;
    end
    start_i = 1'b0;
  endtask

  initial begin
    int oe_cnt, done_at, out_bad;
    logic [2:0] held;
    cfg[0] = FL; cfg[1] = FL; cfg[2] = FL;
    repeat (3) @(negedge clk);
    check("R1 oe", pad_oe_o, 0);
    check("R1 done", done_o, 0);
    check("R1 mode", mode_o, 3'b111);
    rst_n = 1'b1;

    // R7: no straps fitted, floating pins start low
    run_probe(1'b0, oe_cnt, done_at, out_bad);
    check("R7 default code", mode_o, 3'b111);

    // R5 R6 R2 R3 R4: all 27 strap combinations
    for (int k = 0; k < 27; k++) begin
      cfg[0] = k % 3; cfg[1] = (k / 3) % 3; cfg[2] = k / 9;
      run_probe(1'b0, oe_cnt, done_at, out_bad);
      check("R5 R6 code", mode_o, expect_code());
      check("R2 pulse width", oe_cnt, P);
      check("R4 done latency", done_at, P + S);
      check("R3 drive only high", out_bad, 0);
    end

    // R6 named codes
    cfg[2] = PU; cfg[1] = FL; cfg[0] = PD;
    run_probe(1'b0, oe_cnt, done_at, out_bad);
    check("R6 usb code", mode_o, 3'b110);
    cfg[2] = FL; cfg[1] = PD; cfg[0] = PU;
    run_probe(1'b0, oe_cnt, done_at, out_bad);
    check("R6 sd code", mode_o, 3'b101);
    cfg[2] = PU; cfg[1] = PD; cfg[0] = PD;
    run_probe(1'b0, oe_cnt, done_at, out_bad);
    check("R6 monitor code", mode_o, 3'b100);

    // R8: pads change after done, result held
    held = mode_o;
    cfg[0] = PU; cfg[1] = PU; cfg[2] = PD;
    repeat (12) @(negedge clk);
    check("R8 mode held", mode_o, held);
    check("R8 done held", done_o, 1);
    check("R8 no drive", pad_oe_o, 0);

    // R9: start pulses during drive and settle ignored
    cfg[0] = PD; cfg[1] = FL; cfg[2] = FL;
    run_probe(1'b1, oe_cnt, done_at, out_bad);
    check("R9 latency unchanged", done_at, P + S);
    check("R9 single pulse", oe_cnt, P);
    check("R9 code", mode_o, 3'b110);

    // R10: rerun clears done next cycle, old mode kept until new result
    held = mode_o;
    cfg[0] = FL; cfg[1] = FL; cfg[2] = PD;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R10 done cleared", done_o, 0);
    check("R10 old mode kept", mode_o, held);
    repeat (P + S + 2) @(negedge clk);
    check("R10 new code", mode_o, 3'b011);
    check("R10 done again", done_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule